// File: doc/BRIEF.md
# SPI Hold Pause Controller

This block lets a master pause an SPI slave transaction without deselecting the slave. It watches the active-low hold pin, the serial clock level and the active-low chip select, all already synchronised to the system clock. From them it makes a hold flag, which freezes the slave's bit counter and shift register, and a tri-state override for the serial data output.

A change on the hold pin takes effect only while the serial clock is low. If the pin changes while the clock is high, the change waits until the clock next goes low. This applies to entering hold and to leaving it. While the flag is set, the block passes no serial clock edge on to the shift logic, so data input and clock activity are ignored and the transaction state is kept. Deselecting the slave clears the hold state. Deselecting while held also gives a one-cycle abort pulse, so the slave can discard the interrupted operation.

Top module: `spi_hold_ctrl`

## Requirements
- R1: With chip select low and the serial clock low, a low level on the hold pin sets hold_o in that same cycle.
- R2: If the hold pin goes low while the serial clock is high, hold_o stays low until the first cycle in which the serial clock is low, and then goes high. If the pin returns high before that cycle, hold is never entered.
- R3: With the serial clock low, a high level on the hold pin clears hold_o in that same cycle. If the pin rises while the serial clock is high, hold_o stays high until the first cycle in which the clock is low.
- R4: so_hiz_o is 1 whenever hold_o is 1 or chip select is high, and 0 otherwise.
- R5: sck_rise_o (or sck_fall_o) is 1 for exactly one cycle when the sampled serial clock is 1 (or 0) and was 0 (or 1) in the previous cycle, but only if chip select is low and hold_o is 0 in that cycle. No edge is reported while hold_o is 1 or while the slave is deselected.
- R6: While chip select is high, hold_o is 0 and the stored hold state is cleared. After reselection with the serial clock high, hold_o stays 0 even when the hold pin is low, until the clock goes low.
- R7: abort_o is 1 for exactly one cycle when chip select is high and hold_o was 1 in the previous cycle. Deselecting while not held gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Synchronised chip select, active low |
| sck_i | input | 1 | Synchronised serial clock level |
| hold_ni | input | 1 | Synchronised hold pin, active low |
| hold_o | output | 1 | Hold flag; freezes the shift logic |
| so_hiz_o | output | 1 | Forces the serial output to high impedance |
| sck_rise_o | output | 1 | Rising serial clock edge, qualified by select and hold |
| sck_fall_o | output | 1 | Falling serial clock edge, qualified by select and hold |
| abort_o | output | 1 | Pulse when the slave is deselected during hold |

## Verification
The bench toggles the hold pin in both serial clock phases. A design that acts on the pin at once would raise or drop hold_o while the clock is still high. The bench also sends a short low pulse on the hold pin during clock high, and a design that latched the falling pin edge would enter hold wrongly. It checks that the clock edges at hold entry and during hold are suppressed and that the falling edge at a deferred release is passed; a design with a one-cycle gating lag would let a shifted bit slip through. It deselects with and without hold and reselects with the clock high, so any stale hold state or extra abort pulse shows up at the ports.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } sck_edge_t;
endpackage

// File: rtl/spi_hold_edge.sv
module spi_hold_edge
  import spi_hold_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sck_i,
  output sck_edge_t edge_o
);
  logic sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_i;
  end

  assign edge_o.rise = sck_i & ~sck_q;
  assign edge_o.fall = ~sck_i & sck_q;
endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic hold_ni,
  output logic hold_o,
  output logic abort_o
);
  logic hold_q;

  // pin is honoured only at SCK low; SCK high keeps the stored state
  always_comb begin
    if (cs_ni)      hold_o = 1'b0;
    else if (sck_i) hold_o = hold_q;
    else            hold_o = ~hold_ni;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b0;
    else         hold_q <= hold_o;
  end

  assign abort_o = cs_ni & hold_q;
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
  import spi_hold_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic hold_ni,
  output logic hold_o,
  output logic so_hiz_o,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic abort_o
);
  sck_edge_t raw_edge;
  logic      hold_w;
  logic      pass_w;

  spi_hold_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_i  (sck_i),
    .edge_o (raw_edge)
  );

  spi_hold_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_ni   (cs_ni),
    .sck_i   (sck_i),
    .hold_ni (hold_ni),
    .hold_o  (hold_w),
    .abort_o (abort_o)
  );

  assign pass_w     = ~cs_ni & ~hold_w;
  assign hold_o     = hold_w;
  assign so_hiz_o   = cs_ni | hold_w;
  assign sck_rise_o = raw_edge.rise & pass_w;
  assign sck_fall_o = raw_edge.fall & pass_w;
endmodule

// File: rtl/spi_hold_ctrl_chk.sv
module spi_hold_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic sck_i,
  input logic hold_ni,
  input logic hold_o,
  input logic so_hiz_o,
  input logic sck_rise_o,
  input logic sck_fall_o,
  input logic abort_o
);
  AST_LOW_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !sck_i && !hold_ni) |-> hold_o); // R1
  AST_HIGH_DEFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && $past(!cs_ni) && sck_i && $past(sck_i)) |-> $stable(hold_o)); // R2
  AST_LOW_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sck_i && hold_ni) |-> !hold_o); // R3
  AST_HIZ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o || cs_ni) |-> so_hiz_o); // R4
  AST_NO_EDGE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o || cs_ni) |-> !(sck_rise_o || sck_fall_o)); // R5
  AST_EDGE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sck_rise_o, sck_fall_o})); // R5
  AST_DESEL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !hold_o); // R6
  AST_ABORT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (cs_ni && $past(hold_o))); // R7
  AST_ABORT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o); // R7
endmodule

bind spi_hold_ctrl spi_hold_ctrl_chk u_chk (.*);

// File: tb/tb_spi_hold_ctrl.sv
module tb_spi_hold_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1;
  logic sck_i = 1'b0;
  logic hold_ni = 1'b1;
  logic hold_o, so_hiz_o, sck_rise_o, sck_fall_o, abort_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [4:0] exp; // {hold, hiz, rise, fall, abort}
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  spi_hold_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sck_i(sck_i),
    .hold_ni(hold_ni), .hold_o(hold_o), .so_hiz_o(so_hiz_o),
    .sck_rise_o(sck_rise_o), .sck_fall_o(sck_fall_o), .abort_o(abort_o)
  );

  task automatic step(input logic cs, input logic sck, input logic hn,
                      input logic [4:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    cs_ni = cs; sck_i = sck; hold_ni = hn;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: samples 2 ns after the drive point, before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb_q.size() > 0) begin
        item_t it;
        logic [4:0] act;
        it = sb_q.pop_front();
        act = {hold_o, so_hiz_o, sck_rise_o, sck_fall_o, abort_o};
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s act=%b exp=%b", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(1, 0, 1, 5'b01000, "R4 reset");
    step(1, 0, 1, 5'b01000, "R4 reset");
    rst_ni = 1'b1;
    step(1, 0, 1, 5'b01000, "R4 deselected");
    step(0, 0, 1, 5'b00000, "R4 selected");
    step(0, 1, 1, 5'b00100, "R5 rise");
    step(0, 0, 1, 5'b00010, "R5 fall");
    step(0, 0, 0, 5'b11000, "R1 enter low");
    step(0, 1, 0, 5'b11000, "R5 rise held");
    step(0, 0, 0, 5'b11000, "R5 fall held");
    step(0, 0, 1, 5'b00000, "R3 exit low");
    step(0, 1, 1, 5'b00100, "R5 rise");
    step(0, 1, 0, 5'b00000, "R2 defer");
    step(0, 1, 0, 5'b00000, "R2 defer");
    step(0, 0, 0, 5'b11000, "R2 enter at low");
    step(0, 1, 0, 5'b11000, "R5 rise held");
    step(0, 1, 1, 5'b11000, "R3 defer exit");
    step(0, 0, 1, 5'b00010, "R3 exit at low");
    step(0, 0, 0, 5'b11000, "R1 enter low");
    step(1, 0, 0, 5'b01001, "R7 abort");
    step(1, 0, 0, 5'b01000, "R7 single pulse");
    step(1, 1, 0, 5'b01000, "R5 no edge deselected");
    step(0, 1, 0, 5'b00000, "R6 reselect cleared");
    step(0, 0, 0, 5'b11000, "R6 hold at low");
    step(1, 0, 1, 5'b01001, "R7 abort");
    step(0, 0, 1, 5'b00000, "R6 unheld");
    step(1, 0, 1, 5'b01000, "R7 no abort");
    step(0, 0, 1, 5'b00000, "R4 selected");
    step(0, 1, 1, 5'b00100, "R5 rise");
    step(0, 1, 0, 5'b00000, "R2 glitch");
    step(0, 1, 1, 5'b00000, "R2 glitch gone");
    step(0, 0, 1, 5'b00010, "R2 no hold");
    @(negedge clk);
    @(negedge clk);
    #3;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule